// File: doc/BRIEF.md
# NAND Flash Page-Read Sequencer

This block is a host-side engine for an 8-bit asynchronous NAND flash bus. It takes one request at a time: a linear page number, a starting byte offset within that page, and a byte count. It then runs the whole single-page read on the flash pins. First it writes the read-setup command and five address bytes, two for the column and three for the row. Next it writes the read-confirm command. It then waits for the device to signal busy and afterwards ready. Last, it strobes the requested bytes out of the device's page buffer one at a time.

Every byte read from the device is handed to a valid/ready output stream, and the stream can stall the strobing at any byte. All pulse widths and the settle delay after the last write strobe are parameters counted in system clock cycles. The ready/busy pin is passed through a two-flop synchronizer. Each of the two waits on that pin is bounded by a timeout. A wait that expires ends the operation and sets an error flag, and the flag holds until the next request is accepted.

Top module: `nand_rd_seq`

## Requirements
- R1: After reset, and whenever no operation is running, the chip-select, write-strobe and read-strobe outputs are high, both latch-enable outputs are low, the data output enable is low, `busy` is low and `out_valid` is low.
- R2: Each operation writes exactly seven bytes to the device in this order: command 0x00 with the command latch high and the address latch low, then five address bytes with the address latch high and the command latch low, then command 0x30 with the command latch high. The two latch enables are never high together.
- R3: Address byte 1 is col[7:0]. Address byte 2 is {4'b0000, col[11:8]}, so a column of 2048 to 2111 keeps bit 11 in the column bytes.
- R4: Address bytes 3, 4 and 5 are page[7:0], page[15:8] and page[23:16]. For page 0x6D640 and column 0x4B8, the five address bytes are B8, 04, 40, D6, 06.
- R5: Each write strobe is low for exactly WE_LO_CYC clock cycles and then high for at least WE_HI_CYC cycles. The output byte stays stable while the strobe is low.
- R6: After the confirm command, no read strobe is issued until the synchronized ready/busy line has been seen low and then high again. That wait begins TWB_CYC cycles after the last write-strobe high phase.
- R7: The block issues exactly `req_len` read strobes. Output byte k is the device byte at column `req_col`+k, so the first byte is the requested column and not column 0. A byte held with `out_valid` high and `out_ready` low stays unchanged. A count of 0 ends the operation after the ready wait with no strobes.
- R8: The data output enable is high only during command and address write cycles. It is low whenever the read strobe is low.
- R9: A request is taken when `req_valid` is high and `busy` is low. `busy` stays high until the operation ends. Requests presented while `busy` is high are ignored and do not change the bytes written or read.
- R10: If the busy edge or the ready edge does not arrive within TMO_CYC cycles of its wait starting, the block sets `err_timeout`, issues no read strobe and returns to idle. The flag clears when the next request is accepted.
- R11: Chip-select is low for the whole of each operation and high once `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_page | input | 24 | Linear page number |
| req_col | input | 12 | Starting byte offset within the page (0 to 2111) |
| req_len | input | 12 | Number of bytes to read |
| busy | output | 1 | Operation in progress; requests are ignored |
| err_timeout | output | 1 | Last operation ended on a ready/busy timeout |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts the output byte |
| out_data | output | 8 | Byte read from the device |
| nf_chip_sel_n | output | 1 | Device chip select, active low |
| nf_cmd_latch | output | 1 | Command latch enable, active high |
| nf_addr_latch | output | 1 | Address latch enable, active high |
| nf_wr_n | output | 1 | Write strobe, active low |
| nf_rd_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Byte driven toward the device |
| nf_dq_oe | output | 1 | Drive enable for the shared data bus |
| nf_dq_i | input | 8 | Byte from the device |
| nf_rdy | input | 1 | Device ready (high) / busy (low) |

## Verification
The checker assumes that the device keeps its ready/busy line high for the whole data phase. It therefore treats any read strobe with that line low as a sequencing fault. The bench's device model follows this rule: it pulls the line low only a few cycles after capturing the confirm command, and it releases the line before any data is requested. The timeout cases, where the line stays low or never goes low, meet the same rule, because the block must then issue no read strobe at all. The consumer's `out_ready` is unconstrained, so the bench drives it with several stall patterns.

// File: rtl/nrs_pkg.sv
package nrs_pkg;

    localparam int ROW_W = 24;
    localparam int COL_W = 12;
    localparam int LEN_W = 12;

    localparam logic [7:0] CMD_SETUP   = 8'h00;
    localparam logic [7:0] CMD_CONFIRM = 8'h30;
    localparam logic [2:0] LAST_IDX    = 3'd6;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WLO,
        S_WHI,
        S_TWB,
        S_WBSY,
        S_WRDY,
        S_RLO,
        S_RHI,
        S_OUT
    } seq_st_e;

    typedef struct packed {
        logic [ROW_W-1:0] page;
        logic [COL_W-1:0] col;
    } rd_req_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_cmd(input logic [2:0] idx);
        return (idx == 3'd0) || (idx == LAST_IDX);
    endfunction

    // Byte written on bus cycle idx: setup, 2 column, 3 row, confirm
    function automatic logic [7:0] seq_byte(input logic [2:0] idx, input rd_req_t r);
        case (idx)
            3'd0:    return CMD_SETUP;
            3'd1:    return r.col[7:0];
            3'd2:    return {4'h0, r.col[11:8]};
            3'd3:    return r.page[7:0];
            3'd4:    return r.page[15:8];
            3'd5:    return r.page[23:16];
            default: return CMD_CONFIRM;
        endcase
    endfunction

endpackage

// File: rtl/nrs_rb_sync.sv
module nrs_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], din};
    end

    assign dout = sh[STAGES-1];
endmodule

// File: rtl/nrs_tmo.sv
module nrs_tmo #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt;

    assign expired = run && (cnt == TW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || restart) cnt <= '0;
        else if (!expired)          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
    import nrs_pkg::*;
#(
    parameter int WE_LO_CYC = 2,
    parameter int WE_HI_CYC = 2,
    parameter int RE_LO_CYC = 2,
    parameter int RE_HI_CYC = 1,
    parameter int TWB_CYC   = 4,
    parameter int TMO_CYC   = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [ROW_W-1:0] req_page,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    output logic             busy,
    output logic             err_timeout,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             nf_chip_sel_n,
    output logic             nf_cmd_latch,
    output logic             nf_addr_latch,
    output logic             nf_wr_n,
    output logic             nf_rd_n,
    output logic [7:0]       nf_dq_o,
    output logic             nf_dq_oe,
    input  logic [7:0]       nf_dq_i,
    input  logic             nf_rdy
);
    localparam int PH_MAX = imax(imax(imax(WE_LO_CYC, WE_HI_CYC),
                                      imax(RE_LO_CYC, RE_HI_CYC)), TWB_CYC);
    localparam int PH_W   = $clog2(PH_MAX + 1);

    seq_st_e          st;
    rd_req_t          req_q;
    logic [2:0]       idx;
    logic [PH_W-1:0]  ph_cnt;
    logic [PH_W-1:0]  ph_lim;
    logic             ph_done;
    logic [LEN_W-1:0] remain;
    logic [7:0]       data_q;
    logic             err_q;
    logic             rdy_s;
    logic             tmo_run;
    logic             tmo_restart;
    logic             tmo_exp;
    logic             wr_phase;

    nrs_rb_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (nf_rdy),
        .dout (rdy_s)
    );

    assign tmo_run     = (st == S_WBSY) || (st == S_WRDY);
    assign tmo_restart = (st == S_WBSY) && !rdy_s;

    nrs_tmo #(.LIMIT(TMO_CYC)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .run     (tmo_run),
        .restart (tmo_restart),
        .expired (tmo_exp)
    );

    always_comb begin
        case (st)
            S_WLO:   ph_lim = PH_W'(WE_LO_CYC);
            S_WHI:   ph_lim = PH_W'(WE_HI_CYC);
            S_TWB:   ph_lim = PH_W'(TWB_CYC);
            S_RLO:   ph_lim = PH_W'(RE_LO_CYC);
            S_RHI:   ph_lim = PH_W'(RE_HI_CYC);
            default: ph_lim = PH_W'(1);
        endcase
    end

    assign ph_done = (ph_cnt == ph_lim - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            req_q  <= '0;
            idx    <= '0;
            ph_cnt <= '0;
            remain <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            case (st)
                S_WLO, S_WHI, S_TWB, S_RLO, S_RHI:
                    ph_cnt <= ph_done ? '0 : ph_cnt + 1'b1;
                default:
                    ph_cnt <= '0;
            endcase

            case (st)
                S_IDLE: if (req_valid) begin
                    req_q  <= '{page: req_page, col: req_col};
                    remain <= req_len;
                    idx    <= '0;
                    err_q  <= 1'b0;
                    st     <= S_WLO;
                end
                S_WLO: if (ph_done) st <= S_WHI;
                S_WHI: if (ph_done) begin
                    if (idx == LAST_IDX) begin
                        st <= S_TWB;
                    end else begin
                        idx <= idx + 3'd1;
                        st  <= S_WLO;
                    end
                end
                S_TWB: if (ph_done) st <= S_WBSY;
                S_WBSY: begin
                    if (!rdy_s) st <= S_WRDY;
                    else if (tmo_exp) begin
                        err_q <= 1'b1;
                        st    <= S_IDLE;
                    end
                end
                S_WRDY: begin
                    if (rdy_s) st <= (remain == '0) ? S_IDLE : S_RLO;
                    else if (tmo_exp) begin
                        err_q <= 1'b1;
                        st    <= S_IDLE;
                    end
                end
                S_RLO: if (ph_done) begin
                    data_q <= nf_dq_i;
                    st     <= S_RHI;
                end
                S_RHI: if (ph_done) st <= S_OUT;
                S_OUT: if (out_ready) begin
                    remain <= remain - 1'b1;
                    st     <= (remain == LEN_W'(1)) ? S_IDLE : S_RLO;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign wr_phase      = (st == S_WLO) || (st == S_WHI);
    assign busy          = (st != S_IDLE);
    assign err_timeout   = err_q;
    assign out_valid     = (st == S_OUT);
    assign out_data      = data_q;
    assign nf_chip_sel_n = (st == S_IDLE);
    assign nf_cmd_latch  = wr_phase && is_cmd(idx);
    assign nf_addr_latch = wr_phase && !is_cmd(idx);
    assign nf_wr_n       = (st != S_WLO);
    assign nf_rd_n       = (st != S_RLO);
    assign nf_dq_oe      = wr_phase;
    assign nf_dq_o       = wr_phase ? seq_byte(idx, req_q) : 8'h00;
endmodule

// File: rtl/nrs_chk.sv
module nrs_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       err_timeout,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       nf_chip_sel_n,
    input logic       nf_cmd_latch,
    input logic       nf_addr_latch,
    input logic       nf_wr_n,
    input logic       nf_rd_n,
    input logic [7:0] nf_dq_o,
    input logic       nf_dq_oe,
    input logic       nf_rdy
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (nf_wr_n && nf_rd_n && !nf_dq_oe && !out_valid)); // R1

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(nf_cmd_latch && nf_addr_latch)); // R2

    AST_WR_DRIVES: assert property (@(posedge clk) disable iff (rst)
        !nf_wr_n |-> (nf_dq_oe && (nf_cmd_latch || nf_addr_latch))); // R5

    AST_WR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!nf_wr_n && $past(!nf_wr_n)) |-> ($stable(nf_dq_o) && $stable(nf_cmd_latch))); // R5

    AST_RD_READY: assert property (@(posedge clk) disable iff (rst)
        !nf_rd_n |-> nf_rdy); // R6

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

    AST_RD_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !nf_rd_n |-> !nf_dq_oe); // R8

    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
        err_timeout |-> !busy); // R10

    AST_CS_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy != nf_chip_sel_n); // R11
endmodule

bind nand_rd_seq nrs_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .err_timeout   (err_timeout),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .nf_chip_sel_n (nf_chip_sel_n),
    .nf_cmd_latch  (nf_cmd_latch),
    .nf_addr_latch (nf_addr_latch),
    .nf_wr_n       (nf_wr_n),
    .nf_rd_n       (nf_rd_n),
    .nf_dq_o       (nf_dq_o),
    .nf_dq_oe      (nf_dq_oe),
    .nf_rdy        (nf_rdy)
);

// File: tb/nand_rd_seq_tb_top.sv
`timescale 1ns/1ps
module nand_rd_seq_tb_top;
    localparam int WE_LO = 2;
    localparam int WE_HI = 2;
    localparam int RE_LO = 2;
    localparam int RE_HI = 1;
    localparam int TWB   = 4;
    localparam int TMO   = 64;
    localparam int BUSY_CYC = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [23:0] req_page = '0;
    logic [11:0] req_col = '0;
    logic [11:0] req_len = '0;
    logic busy, err_timeout, out_valid;
    logic out_ready = 1'b0;
    logic [7:0] out_data;
    logic nf_chip_sel_n, nf_cmd_latch, nf_addr_latch, nf_wr_n, nf_rd_n, nf_dq_oe;
    logic [7:0] nf_dq_o;
    logic [7:0] nf_dq_i = 8'h00;
    logic nf_rdy = 1'b1;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    nand_rd_seq #(
        .WE_LO_CYC(WE_LO), .WE_HI_CYC(WE_HI), .RE_LO_CYC(RE_LO),
        .RE_HI_CYC(RE_HI), .TWB_CYC(TWB), .TMO_CYC(TMO)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_page(req_page),
        .req_col(req_col), .req_len(req_len), .busy(busy),
        .err_timeout(err_timeout), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .nf_chip_sel_n(nf_chip_sel_n),
        .nf_cmd_latch(nf_cmd_latch), .nf_addr_latch(nf_addr_latch),
        .nf_wr_n(nf_wr_n), .nf_rd_n(nf_rd_n), .nf_dq_o(nf_dq_o),
        .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i), .nf_rdy(nf_rdy)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] dev_byte(input logic [23:0] p, input logic [11:0] c);
        return p[7:0] * 8'd5 + c[7:0] + {c[11:8], 4'h0} + p[15:8];
    endfunction

    // ---------------- device model ----------------
    logic [7:0] rec_d [16];
    logic       rec_c [16];
    logic       rec_a [16];
    int         rec_n = 0;
    logic [23:0] dev_page = '0;
    logic [11:0] dev_ptr = '0;
    bit stuck = 0;
    bit no_busy = 0;
    event confirm_ev;

    always @(posedge nf_wr_n) begin
        if (!rst) begin
            if (rec_n < 16) begin
                rec_d[rec_n] = nf_dq_o;
                rec_c[rec_n] = nf_cmd_latch;
                rec_a[rec_n] = nf_addr_latch;
            end
            rec_n++;
            if (nf_cmd_latch && nf_dq_o == 8'h30 && rec_n >= 6) begin
                dev_page = {rec_d[5], rec_d[4], rec_d[3]};
                dev_ptr  = {rec_d[2][3:0], rec_d[1]};
                -> confirm_ev;
            end
        end
    end

    always begin
        @(confirm_ev);
        repeat (2) @(posedge clk);
        if (!no_busy) begin
            nf_rdy = 1'b0;
            repeat (BUSY_CYC) @(posedge clk);
            wait (!stuck);
            nf_rdy = 1'b1;
        end
    end

    always @(negedge nf_rd_n) nf_dq_i = dev_byte(dev_page, dev_ptr);
    always @(posedge nf_rd_n) if (!rst) dev_ptr = dev_ptr + 12'd1;

    // ---------------- pin monitors ----------------
    int we_lo_run = 0, we_bad = 0, re_falls = 0, rd_early = 0, oe_bad = 0, cs_bad = 0;
    bit prev_we = 1, prev_re = 1, conf_seen = 0, low_seen = 0, ready_ok = 0;

    always @(confirm_ev) conf_seen = 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (!nf_wr_n) we_lo_run++;
            else begin
                if (!prev_we && we_lo_run != WE_LO) we_bad++;
                we_lo_run = 0;
            end
            if (prev_re && !nf_rd_n) re_falls++;
            if (conf_seen && !nf_rdy) low_seen = 1;
            if (low_seen && nf_rdy) ready_ok = 1;
            if (!nf_rd_n && !ready_ok) rd_early++;
            if (nf_dq_oe && (!nf_rd_n || nf_chip_sel_n)) oe_bad++;
            if (!nf_dq_oe && !nf_wr_n) oe_bad++;
            if (busy == nf_chip_sel_n) cs_bad++;
            prev_we = nf_wr_n;
            prev_re = nf_rd_n;
        end
    end

    // ---------------- operation task ----------------
    int got_n;
    int mism;

    task automatic run_op(input logic [23:0] pg, input logic [11:0] cl,
                          input logic [11:0] ln, input int rmode, input bit spam,
                          input bit check_data);
        int cyc = 0;
        rec_n = 0; we_bad = 0; re_falls = 0; rd_early = 0; oe_bad = 0; cs_bad = 0;
        conf_seen = 0; low_seen = 0; ready_ok = 0;
        got_n = 0; mism = 0;
        @(negedge clk);
        req_page = pg; req_col = cl; req_len = ln; req_valid = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
        chk(err_timeout == 1'b0, "R10", "error cleared on accept", err_timeout, 0);
        req_valid = spam;
        if (spam) begin
            req_page = ~pg; req_col = cl ^ 12'h0A5; req_len = ln + 12'd3;
        end
        while ((busy || out_valid) && cyc < 20000) begin
            case (rmode)
                0: out_ready = 1'b1;
                1: out_ready = cyc[0];
                default: out_ready = (cyc % 4 == 3);
            endcase
            if (out_valid && out_ready) begin
                if (check_data && out_data !== dev_byte(pg, cl + 12'(got_n))) begin
                    if (mism == 0)
                        chk(0, "R7", $sformatf("byte %0d", got_n), out_data,
                            dev_byte(pg, cl + 12'(got_n)));
                    mism++;
                end
                got_n++;
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        out_ready = 1'b0;
    endtask

    task automatic check_bus(input logic [23:0] pg, input logic [11:0] cl);
        logic [7:0] exp_b [7];
        exp_b[0] = 8'h00; exp_b[1] = cl[7:0]; exp_b[2] = {4'h0, cl[11:8]};
        exp_b[3] = pg[7:0]; exp_b[4] = pg[15:8]; exp_b[5] = pg[23:16]; exp_b[6] = 8'h30;
        chk(rec_n == 7, "R2", "write cycle count", rec_n, 7);
        for (int i = 0; i < 7 && i < rec_n; i++) begin
            if (i == 0 || i == 6) begin
                chk(rec_c[i] && !rec_a[i] && rec_d[i] == exp_b[i], "R2",
                    $sformatf("command byte %0d", i), rec_d[i], exp_b[i]);
            end else if (i < 3) begin
                chk(rec_a[i] && !rec_c[i] && rec_d[i] == exp_b[i], "R3",
                    $sformatf("column byte %0d", i), rec_d[i], exp_b[i]);
            end else begin
                chk(rec_a[i] && !rec_c[i] && rec_d[i] == exp_b[i], "R4",
                    $sformatf("row byte %0d", i), rec_d[i], exp_b[i]);
            end
        end
        chk(we_bad == 0, "R5", "write strobe low width", we_bad, 0);
        chk(oe_bad == 0, "R8", "bus drive enable misuse", oe_bad, 0);
        chk(cs_bad == 0, "R11", "chip select vs busy", cs_bad, 0);
    endtask

    // ---------------- stimulus ----------------
    logic [23:0] pages [5];
    logic [11:0] cols  [5];
    logic [11:0] lens  [3];

    initial begin
        pages[0] = 24'h06D640; pages[1] = 24'h000000; pages[2] = 24'hFFFFFF;
        pages[3] = 24'h000040; pages[4] = 24'h123456;
        cols[0] = 12'h4B8; cols[1] = 12'h000; cols[2] = 12'h7FF;
        cols[3] = 12'h800; cols[4] = 12'h83F;
        lens[0] = 12'd1; lens[1] = 12'd3; lens[2] = 12'd5;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(nf_chip_sel_n && nf_wr_n && nf_rd_n && !nf_cmd_latch && !nf_addr_latch
            && !nf_dq_oe && !busy && !out_valid, "R1", "reset idle pins",
            {nf_chip_sel_n, nf_wr_n, nf_rd_n, nf_cmd_latch, nf_addr_latch, nf_dq_oe, busy, out_valid},
            8'b1110_0000);

        // fixed vector: B8 04 40 D6 06
        run_op(24'h06D640, 12'h4B8, 12'd2, 0, 0, 1);
        chk({rec_d[1], rec_d[2], rec_d[3], rec_d[4], rec_d[5]} == 40'hB8_04_40_D6_06,
            "R4", "reference address bytes",
            int'({rec_d[3], rec_d[4], rec_d[5]}), int'(24'h40D606));

        // sweep
        for (int p = 0; p < 5; p++) begin
            for (int c = 0; c < 5; c++) begin
                for (int l = 0; l < 3; l++) begin
                    run_op(pages[p], cols[c], lens[l], (p + c + l) % 3, 0, 1);
                    check_bus(pages[p], cols[c]);
                    chk(got_n == int'(lens[l]), "R7", "bytes delivered", got_n, lens[l]);
                    chk(re_falls == int'(lens[l]), "R7", "read strobes", re_falls, lens[l]);
                    chk(rd_early == 0, "R6", "read strobe before ready", rd_early, 0);
                    chk(!busy && nf_chip_sel_n, "R11", "idle after operation", busy, 0);
                end
            end
        end

        // requests while busy are ignored
        run_op(24'h0ABCDE, 12'h123, 12'd4, 2, 1, 1);
        check_bus(24'h0ABCDE, 12'h123);
        chk(got_n == 4 && mism == 0, "R9", "ignored requests while busy", got_n, 4);
        @(negedge clk);
        chk(!busy, "R9", "no extra operation started", busy, 0);

        // zero-length request
        run_op(24'h000777, 12'h010, 12'd0, 0, 0, 1);
        check_bus(24'h000777, 12'h010);
        chk(re_falls == 0 && got_n == 0, "R7", "zero count strobes", re_falls, 0);

        // stuck busy: ready edge never comes
        stuck = 1;
        run_op(24'h000100, 12'h020, 12'd4, 0, 0, 0);
        chk(err_timeout == 1'b1, "R10", "timeout on ready wait", err_timeout, 1);
        chk(re_falls == 0, "R10", "no strobe after timeout", re_falls, 0);
        chk(!busy, "R10", "idle after timeout", busy, 0);
        stuck = 0;
        repeat (4) @(negedge clk);

        // busy edge never comes
        no_busy = 1;
        run_op(24'h000200, 12'h030, 12'd4, 0, 0, 0);
        chk(err_timeout == 1'b1, "R10", "timeout on busy wait", err_timeout, 1);
        chk(re_falls == 0, "R6", "no strobe without busy edge", re_falls, 0);
        no_busy = 0;

        // recovery: error clears on next accept
        run_op(24'h000300, 12'h040, 12'd2, 1, 0, 1);
        chk(err_timeout == 1'b0 && got_n == 2, "R10", "recovery after timeout", err_timeout, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule